// File: doc/BRIEF.md
# Stuff Command Majority Decoder

This block sits behind the frame aligner of a time-division demultiplexer and decodes the stuff command carried in each monitored overhead message. Each overhead message carries a command field. The block compares that field, one bit at a time, against three fixed patterns: positive stuff, negative stuff and no action. A saturating error counter for each pattern records the number of mismatches. A message-start strobe clears all three counters.

A word-28 timing strobe reads the three counters. The block then registers a positive-stuff flag or a negative-stuff flag, or leaves both low for no action. Each flag holds until the next word-28 strobe. On the same strobe the block emits one vote for the frame-sync maintenance logic. It votes count-up when at least one pattern was received cleanly enough, and count-down when none was. A pattern counts as received when its counter is below the failure limit, which is eight by default.

Top module: `stuff_cmd_decoder`

## Requirements
- R1: After a message start, the first bit accepted with `bit_stb` high is message bit 0, and the index rises by one on each further accepted bit. Message bit i is compared with bit i (LSB = bit 0) of `POS_CODE`, `NEG_CODE` and `NUL_CODE`. `rx_bit` is ignored in cycles where `bit_stb` is low.
- R2: Each counter adds one per mismatching bit and saturates at `FAIL_LIMIT` (8). Sixteen mismatches leave it at the limit and never wrap it to a passing value.
- R3: `msg_start` clears all three counters and the bit index. When `msg_start` and `bit_stb` are high in the same cycle, the clear wins and that bit is dropped.
- R4: Bits accepted after the first `CODE_LEN` (16) bits of a message have no effect on any counter.
- R5: On the clock edge that samples `w28_stb` high, `stuff_pos` becomes 1 exactly when the positive counter is below 8 and the negative counter is at or above 8. `stuff_neg` follows the same rule with the two counters swapped. Both flags are visible one cycle after the strobe.
- R6: When both stuff counters are below 8, or both are at or above 8, both flags are set low. This is the no-action result.
- R7: Reset clears all outputs to 0. Between two word-28 strobes, `stuff_pos` and `stuff_neg` keep their values.
- R8: `vote_up` is a one-cycle pulse in the cycle after a word-28 strobe, issued when at least one of the three counters is below 8.
- R9: `vote_dn` is a one-cycle pulse in the cycle after a word-28 strobe, issued when all three counters are at or above 8. `vote_up` and `vote_dn` are never high together, and neither pulses without a strobe.
- R10: The word-28 strobe does not clear the counters. A second strobe with no new message repeats the same decision and vote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | Qualifies `rx_bit` as one command bit |
| rx_bit | input | 1 | Received command bit |
| msg_start | input | 1 | Start of an overhead message; clears the counters |
| w28_stb | input | 1 | Word-28 decision strobe |
| stuff_pos | output | 1 | Positive stuff decoded (held) |
| stuff_neg | output | 1 | Negative stuff decoded (held) |
| vote_up | output | 1 | Sync-health count-up pulse |
| vote_dn | output | 1 | Sync-health count-down pulse |

## Verification
The bench applies exact copies of each of the three patterns, which separates the positive, negative and no-action results. It also applies corrupted patterns. One has 7 positive errors with the negative pattern also passing, which gives no action by ambiguity. One fails all three patterns, which separates count-up from count-down. One exact no-action pattern leaves 16 errors on the positive counter, which exposes a counter that wraps instead of saturating.

Further stimuli cover the ordering rules. One message is abandoned and restarted. One start collides with a bit. One message sits at 7 errors and has trailing surplus bits. One message has idle cycles with a toggling data line. One strobe is repeated with no new message.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int NUM_CODES = 3;
  typedef enum int {
    CODE_POS = 0,
    CODE_NEG = 1,
    CODE_NUL = 2
  } code_sel_e;
endpackage

// File: rtl/sc_bit_index.sv
module sc_bit_index #(
  parameter int CODE_LEN = 16,
  localparam int IDX_W = $clog2(CODE_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             in_range
);
  assign in_range = (idx < IDX_W'(CODE_LEN));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx <= '0;
    end else if (adv && in_range) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/sc_err_counter.sv
module sc_err_counter #(
  parameter int LIMIT = 8,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             miss,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (miss && (cnt != CNT_W'(LIMIT))) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sc_decide.sv
module sc_decide (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic [2:0] pass,
  output logic       stuff_pos,
  output logic       stuff_neg,
  output logic       vote_up,
  output logic       vote_dn
);
  import sc_pkg::*;

  logic pos_ok, neg_ok, any_ok;
  assign pos_ok = pass[CODE_POS];
  assign neg_ok = pass[CODE_NEG];
  assign any_ok = |pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      stuff_pos <= 1'b0;
      stuff_neg <= 1'b0;
      vote_up   <= 1'b0;
      vote_dn   <= 1'b0;
    end else begin
      vote_up <= strobe && any_ok;
      vote_dn <= strobe && !any_ok;
      if (strobe) begin
        stuff_pos <= pos_ok && !neg_ok;
        stuff_neg <= neg_ok && !pos_ok;
      end
    end
  end
endmodule

// File: rtl/stuff_cmd_decoder.sv
module stuff_cmd_decoder #(
  parameter int                  CODE_LEN   = 16,
  parameter int                  FAIL_LIMIT = 8,
  parameter logic [CODE_LEN-1:0] POS_CODE   = 16'hFFFF,
  parameter logic [CODE_LEN-1:0] NEG_CODE   = 16'h00FF,
  parameter logic [CODE_LEN-1:0] NUL_CODE   = 16'h0000
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  input  logic rx_bit,
  input  logic msg_start,
  input  logic w28_stb,
  output logic stuff_pos,
  output logic stuff_neg,
  output logic vote_up,
  output logic vote_dn
);
  import sc_pkg::*;

  localparam int IDX_W = $clog2(CODE_LEN + 1);
  localparam int SEL_W = $clog2(CODE_LEN);
  localparam int CNT_W = $clog2(FAIL_LIMIT + 1);

  logic [IDX_W-1:0]    bit_idx;
  logic                idx_ok;
  logic                take_bit;
  logic [CODE_LEN-1:0] code_tab [NUM_CODES];
  logic [NUM_CODES-1:0][CNT_W-1:0] err_cnt;
  logic [NUM_CODES-1:0] pass;

  assign code_tab[CODE_POS] = POS_CODE;
  assign code_tab[CODE_NEG] = NEG_CODE;
  assign code_tab[CODE_NUL] = NUL_CODE;

  // A start strobe wins over a same-cycle bit.
  assign take_bit = bit_stb && !msg_start && idx_ok;

  sc_bit_index #(.CODE_LEN(CODE_LEN)) u_index (
    .clk      (clk),
    .rst      (rst),
    .clr      (msg_start),
    .adv      (take_bit),
    .idx      (bit_idx),
    .in_range (idx_ok)
  );

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    logic miss;
    assign miss = take_bit && (rx_bit != code_tab[g][bit_idx[SEL_W-1:0]]);

    sc_err_counter #(.LIMIT(FAIL_LIMIT)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (msg_start),
      .miss (miss),
      .cnt  (err_cnt[g])
    );

    assign pass[g] = (err_cnt[g] < CNT_W'(FAIL_LIMIT));
  end

  sc_decide u_decide (
    .clk       (clk),
    .rst       (rst),
    .strobe    (w28_stb),
    .pass      (pass),
    .stuff_pos (stuff_pos),
    .stuff_neg (stuff_neg),
    .vote_up   (vote_up),
    .vote_dn   (vote_dn)
  );
endmodule

// File: rtl/stuff_cmd_decoder_chk.sv
module stuff_cmd_decoder_chk #(
  parameter int FAIL_LIMIT = 8,
  parameter int CNT_W      = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  msg_start,
  input logic                  w28_stb,
  input logic                  stuff_pos,
  input logic                  stuff_neg,
  input logic                  vote_up,
  input logic                  vote_dn,
  input logic [2:0][CNT_W-1:0] err_cnt
);
  assert_cap_R2: assert property (@(posedge clk) disable iff (rst)
    (err_cnt[0] <= CNT_W'(FAIL_LIMIT)) && (err_cnt[1] <= CNT_W'(FAIL_LIMIT)) &&
    (err_cnt[2] <= CNT_W'(FAIL_LIMIT)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    msg_start |=> (err_cnt[0] == '0) && (err_cnt[1] == '0) && (err_cnt[2] == '0));

  assert_flag_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(stuff_pos && stuff_neg));

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(w28_stb) && !$past(rst)) |-> ($stable(stuff_pos) && $stable(stuff_neg)));

  assert_vote_src_R8: assert property (@(posedge clk) disable iff (rst)
    (vote_up || vote_dn) |-> $past(w28_stb));

  assert_vote_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vote_up, vote_dn}));
endmodule

bind stuff_cmd_decoder stuff_cmd_decoder_chk #(
  .FAIL_LIMIT (FAIL_LIMIT),
  .CNT_W      (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .msg_start (msg_start),
  .w28_stb   (w28_stb),
  .stuff_pos (stuff_pos),
  .stuff_neg (stuff_neg),
  .vote_up   (vote_up),
  .vote_dn   (vote_dn),
  .err_cnt   (err_cnt)
);

// File: tb/stuff_cmd_decoder_bench.sv
`timescale 1ns/1ps
module stuff_cmd_decoder_bench;
  localparam logic [15:0] PC = 16'hFFFF;
  localparam logic [15:0] NC = 16'h00FF;
  localparam logic [15:0] ZC = 16'h0000;
  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_stb = 1'b0, rx_bit = 1'b0, msg_start = 1'b0, w28_stb = 1'b0;
  logic stuff_pos, stuff_neg, vote_up, vote_dn;

  always #2.5 clk = ~clk;

  stuff_cmd_decoder u_stuff_cmd_decoder (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .msg_start(msg_start), .w28_stb(w28_stb),
    .stuff_pos(stuff_pos), .stuff_neg(stuff_neg),
    .vote_up(vote_up), .vote_dn(vote_dn)
  );

  typedef struct packed { logic p; logic n; logic u; logic d; } exp_t;
  exp_t scb[$];
  int checks = 0;
  int fails  = 0;
  int e_cnt [3];
  logic cur_p = 1'b0, cur_n = 1'b0;
  bit armed = 1'b0;
  bit done  = 1'b0;
  string tag = "";

  function automatic logic cbit(int c, int i);
    return (c == 0) ? PC[i] : (c == 1) ? NC[i] : ZC[i];
  endfunction

  // R1 R3 R4: one message; extra bits past 16 carry 'fill'.
  task automatic drive_msg(input logic [15:0] pat, input int nbits,
                           input bit collide, input int gap, input logic fill);
    @(negedge clk);
    msg_start = 1'b1;
    if (collide) begin
      bit_stb = 1'b1;
      rx_bit  = ~pat[0];
    end
    @(negedge clk);
    msg_start = 1'b0;
    bit_stb   = 1'b0;
    for (int c = 0; c < 3; c++) e_cnt[c] = 0;
    for (int i = 0; i < nbits; i++) begin
      rx_bit  = (i < 16) ? pat[i] : fill;
      bit_stb = 1'b1;
      if (i < 16)
        for (int c = 0; c < 3; c++)
          if (pat[i] != cbit(c, i) && e_cnt[c] < LIM) e_cnt[c]++;
      @(negedge clk);
      bit_stb = 1'b0;
      for (int k = 0; k < gap; k++) begin
        rx_bit = ~rx_bit;
        @(negedge clk);
      end
    end
  endtask

  // R5 R6 R8 R9 R10: strobe and push the expected outcome.
  task automatic fire_w28(input string t);
    exp_t e;
    logic pok, nok, zok;
    pok = e_cnt[0] < LIM;
    nok = e_cnt[1] < LIM;
    zok = e_cnt[2] < LIM;
    e.p = pok && !nok;
    e.n = nok && !pok;
    e.u = pok || nok || zok;
    e.d = !(pok || nok || zok);
    tag = t;
    scb.push_back(e);
    w28_stb = 1'b1;
    @(negedge clk);
    w28_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops on each vote pulse; checks flag hold otherwise (R7).
  always @(negedge clk) begin
    if (!rst && armed) begin
      if (vote_up || vote_dn) begin
        checks++;
        if (scb.size() == 0) begin
          fails++;
          $display("FAIL R8/R9 unexpected vote up=%0b dn=%0b expected none", vote_up, vote_dn);
        end else begin
          exp_t e;
          e = scb.pop_front();
          cur_p = e.p;
          cur_n = e.n;
          if ({stuff_pos, stuff_neg, vote_up, vote_dn} != {e.p, e.n, e.u, e.d}) begin
            fails++;
            $display("FAIL R5/R6/R8/R9 [%s] pos/neg/up/dn actual=%b%b%b%b expected=%b%b%b%b",
                     tag, stuff_pos, stuff_neg, vote_up, vote_dn, e.p, e.n, e.u, e.d);
          end
        end
      end else begin
        checks++;
        if (stuff_pos != cur_p || stuff_neg != cur_n) begin
          fails++;
          $display("FAIL R7 hold [%s] pos/neg actual=%b%b expected=%b%b",
                   tag, stuff_pos, stuff_neg, cur_p, cur_n);
        end
      end
    end
  end

  initial begin
    #(100000 * 5.0);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if ({stuff_pos, stuff_neg, vote_up, vote_dn} != 4'b0000) begin
      fails++;
      $display("FAIL R7 reset actual=%b%b%b%b expected=0000",
               stuff_pos, stuff_neg, vote_up, vote_dn);
    end
    armed = 1'b1;

    drive_msg(PC, 16, 0, 0, 1'b0); fire_w28("R1 exact positive");
    drive_msg(NC, 16, 0, 0, 1'b0); fire_w28("R5 exact negative");
    drive_msg(ZC, 16, 0, 0, 1'b0); fire_w28("R2 no-action, positive saturates");
    drive_msg(16'h0F0F, 16, 0, 0, 1'b0); fire_w28("R9 all fail");
    drive_msg(16'h0FFF, 16, 0, 0, 1'b0); fire_w28("R6 both stuff pass");
    fire_w28("R10 repeat strobe");
    drive_msg(PC, 16, 1, 0, 1'b0); fire_w28("R3 start collides with bit");
    drive_msg(16'hFF00, 8, 0, 0, 1'b0);
    drive_msg(NC, 16, 0, 0, 1'b0); fire_w28("R3 restart mid message");
    drive_msg(16'h0001, 20, 0, 0, 1'b0); fire_w28("R4 surplus bits ignored");
    drive_msg(PC, 16, 0, 2, 1'b0); fire_w28("R1 idle cycles toggling");
    drive_msg(16'h01FF, 16, 0, 0, 1'b0); fire_w28("R2 seven errors pass");
    drive_msg(16'hFE00, 16, 0, 0, 1'b0); fire_w28("R6 both stuff fail");
    drive_msg(NC, 16, 0, 0, 1'b0); fire_w28("R5 negative again");
    drive_msg(PC, 12, 0, 0, 1'b0); fire_w28("R1 short message");

    repeat (4) @(negedge clk);
    checks++;
    if (scb.size() != 0) begin
      fails++;
      $display("FAIL R8/R9 missing votes actual=%0d pending expected=0", scb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule